// File: doc/BRIEF.md
# Reset Status and Control Register

This block holds one 32-bit word that records why the system last came out of reset. Software uses the same word to ask for a new reset. A write can request a soft cold (power-on) reset or a soft warm (externally initiated) reset. Either request produces a one-cycle pulse on `reset_req`, which goes to the system reset sequencer. The sequencer itself is outside this block.

The block sees two kinds of reset. Its own synchronous reset, `rst_n`, clears everything. Each later system reset is signalled by a one-cycle pulse on `rst_event`. A small saturating counter tracks these events. The first event after the counter is zero loads the power-on flag alone. Later events leave the word untouched, so software can still read the cause of the previous reset.

A soft cold request clears the counter, so the reset that follows marks itself as power-on again. Two pulse inputs come from already debounced push-buttons, one cold and one warm, and each sets a sticky cause bit.

Top module: `rst_status_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, the stored word is 0 and `reset_req` is 0.
- R2: The register answers only when `bus_addr[15:3]` equals `BASE_ADDR[15:3]` and `bus_addr[2]` is 1, with default base 0xF020, so the active word is at 0xF024. `bus_addr[1:0]` are ignored. Any other address reads 0, and writes to it change nothing.
- R3: Only bits 31 to 27 are stored. Bits 26 to 0 always read 0.
- R4: Bits 31 (power-on flag), 28 (button cold) and 27 (button warm) are write-one-to-clear. Writing 0 to any of them leaves it unchanged.
- R5: Bits 30 (soft cold) and 29 (soft warm) take the value written, whether 0 or 1.
- R6: An accepted write with bit 30 = 1 raises `reset_req` for exactly the one cycle after the write edge. The same write clears the reset counter, so the next `rst_event` loads 0x8000_0000.
- R7: An accepted write with bit 29 = 1 and bit 30 = 0 also raises the one-cycle `reset_req` pulse. It leaves the counter unchanged.
- R8: An `rst_event` while the counter is zero loads the word with 0x8000_0000 and advances the counter.
- R9: An `rst_event` while the counter is nonzero leaves the word unchanged.
- R10: The counter saturates at 2^CNT_W−1 and never wraps, so any number of events after the first does not reload the power-on flag.
- R11: A pulse on `btn_cold_evt` sets bit 28, and a pulse on `btn_warm_evt` sets bit 27. A button set wins over a clear of the same bit written in the same cycle.
- R12: A bus write in the same cycle as `rst_event` is discarded. It changes no bit, raises no request and does not clear the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| bus_addr | input | ADDR_W (16) | Register bus byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| rst_event | input | 1 | One-cycle pulse per completed system reset |
| btn_cold_evt | input | 1 | Debounced cold push-button pulse |
| btn_warm_evt | input | 1 | Debounced warm push-button pulse |
| reset_req | output | 1 | One-cycle system reset request |

## Verification
The counter has no port, so a wrong count shows up only one reset later. It appears as a power-on flag that is missing or wrongly reloaded in the word read back after the next `rst_event`. The bench therefore follows every counter-affecting action with an event and a read. This covers the soft cold clear, the soft warm non-clear and saturation after twenty events.

A stuck or mis-typed bit appears on `bus_rdata` right after the write edge. A stretched or missing request appears on `reset_req` within one cycle of the write, or in the cycle after that.

// File: rtl/rsc_pkg.sv
// Package: shared constants and field classification for the reset status
// and control word. Assumes a fixed 32-bit word with causes in bits 31..27.
package rsc_pkg;
    localparam int DATA_W      = 32;
    localparam int PWRON_BIT   = 31;
    localparam int SW_COLD_BIT = 30;
    localparam int SW_WARM_BIT = 29;
    localparam int BTN_COLD_BIT = 28;
    localparam int BTN_WARM_BIT = 27;
    localparam logic [DATA_W-1:0] PWRON_WORD = 32'h8000_0000;

    typedef enum logic [1:0] {
        FK_NONE = 2'd0,
        FK_W1C  = 2'd1,
        FK_RW   = 2'd2
    } field_kind_e;

    // Classify a bit position of the word.
    function automatic field_kind_e field_kind(input int pos);
        if (pos == PWRON_BIT || pos == BTN_COLD_BIT || pos == BTN_WARM_BIT)
            return FK_W1C;
        else if (pos == SW_COLD_BIT || pos == SW_WARM_BIT)
            return FK_RW;
        else
            return FK_NONE;
    endfunction
endpackage

// File: rtl/rsc_decode.sv
// Address decode: selects the active word of an 8-byte window.
// Assumes ADDR_W >= 4 and a base aligned to 8 bytes.
module rsc_decode #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              word_sel
);
    localparam logic [ADDR_W-4:0] WIN_TAG = BASE_ADDR[ADDR_W-1:3];

    logic unused_low_bits;

    // Window match plus the bit-2 word select.
    always_comb begin
        word_sel = (addr[ADDR_W-1:3] == WIN_TAG) && addr[2];
    end

    assign unused_low_bits = ^addr[1:0];
endmodule

// File: rtl/rsc_reset_counter.sv
// Saturating count of system reset events; cleared by a soft cold request.
// Assumes an event and a clear never need to act in the same cycle (event wins).
module rsc_reset_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt_q,
    output logic             cnt_zero
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Count events up to the ceiling, or clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (evt) begin
            if (cnt_q != CNT_MAX)
                cnt_q <= cnt_q + 1'b1;
        end else if (clr) begin
            cnt_q <= '0;
        end
    end

    // Flag the "first reset" condition for the status word.
    always_comb begin
        cnt_zero = (cnt_q == '0);
    end
endmodule

// File: rtl/rsc_status_bits.sv
// Storage of the cause word, one cell per bit, each typed by the package.
// Assumes wr_act is already gated off during a reset event.
module rsc_status_bits
    import rsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_pwron,
    input  logic              wr_act,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] set_vec,
    output logic [DATA_W-1:0] status_q
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (field_kind(i) == FK_W1C) begin : g_w1c
            localparam logic LOAD_VAL = (i == PWRON_BIT);
            logic bit_q;
            // Sticky cause bit: load, set by hardware, clear by writing one.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bit_q <= 1'b0;
                else if (load_pwron)
                    bit_q <= LOAD_VAL;
                else if (set_vec[i])
                    bit_q <= 1'b1;
                else if (wr_act && wdata[i])
                    bit_q <= 1'b0;
            end
            assign status_q[i] = bit_q;
        end else if (field_kind(i) == FK_RW) begin : g_rw
            logic bit_q;
            logic unused_set;
            // Command bit: holds the last written value.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bit_q <= 1'b0;
                else if (load_pwron)
                    bit_q <= 1'b0;
                else if (wr_act)
                    bit_q <= wdata[i];
            end
            assign status_q[i] = bit_q;
            assign unused_set  = set_vec[i];
        end else begin : g_none
            logic unused_in;
            assign status_q[i] = 1'b0;
            assign unused_in   = wdata[i] ^ set_vec[i];
        end
    end
endmodule

// File: rtl/rsc_req_pulse.sv
// Turns an accepted command write into a registered one-cycle request.
// Assumes wr_act is high for one cycle per write.
module rsc_req_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_act,
    input  logic cold_cmd,
    input  logic warm_cmd,
    output logic req_q,
    output logic clr_cnt
);
    // Register the request so it lands the cycle after the write edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            req_q <= 1'b0;
        else
            req_q <= wr_act && (cold_cmd || warm_cmd);
    end

    // Only a cold command re-arms the power-on flag.
    always_comb begin
        clr_cnt = wr_act && cold_cmd;
    end
endmodule

// File: rtl/rst_status_ctrl.sv
// Top: reset cause word with soft reset requests and a saturating reset count.
// Assumes rst_event, btn_*_evt and bus_wr are single-cycle pulses in clk domain.
module rst_status_ctrl
    import rsc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020,
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rst_event,
    input  logic              btn_cold_evt,
    input  logic              btn_warm_evt,
    output logic              reset_req
);
    logic              word_sel;
    logic              wr_act;
    logic              load_pwron;
    logic              clr_cnt;
    logic              cnt_zero;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] status_q;

    rsc_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
        .addr     (bus_addr),
        .word_sel (word_sel)
    );

    // Accept writes only to the active word and never during a reset event.
    always_comb begin
        wr_act     = bus_wr && word_sel && !rst_event;
        load_pwron = rst_event && cnt_zero;
        set_vec    = '0;
        set_vec[BTN_COLD_BIT] = btn_cold_evt;
        set_vec[BTN_WARM_BIT] = btn_warm_evt;
    end

    rsc_reset_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (rst_event),
        .clr      (clr_cnt),
        .cnt_q    (cnt_q),
        .cnt_zero (cnt_zero)
    );

    rsc_status_bits u_bits (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_pwron (load_pwron),
        .wr_act     (wr_act),
        .wdata      (bus_wdata),
        .set_vec    (set_vec),
        .status_q   (status_q)
    );

    rsc_req_pulse u_req (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_act   (wr_act),
        .cold_cmd (bus_wdata[SW_COLD_BIT]),
        .warm_cmd (bus_wdata[SW_WARM_BIT]),
        .req_q    (reset_req),
        .clr_cnt  (clr_cnt)
    );

    // Read mux: the active word returns the causes, everything else zero.
    always_comb begin
        bus_rdata = word_sel ? status_q : '0;
    end
endmodule

// File: rtl/rst_status_ctrl_chk.sv
// Checker: temporal properties of the reset status register, bound to the top.
module rst_status_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020,
    parameter int CNT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              rst_event,
    input logic              btn_cold_evt,
    input logic              reset_req,
    input logic [31:0]       status_q,
    input logic [CNT_W-1:0]  cnt_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic hit;
    logic wr_ok;
    assign hit   = (bus_addr[ADDR_W-1:3] == BASE_ADDR[ADDR_W-1:3]) && bus_addr[2];
    assign wr_ok = bus_wr && hit && !rst_event;

    a_r3_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[26:0] == 27'd0);

    a_r2_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> bus_rdata == 32'd0);

    a_r6_req_after_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && (bus_wdata[30] || bus_wdata[29])) |=> reset_req);

    a_r7_req_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> $past(wr_ok && (bus_wdata[30] || bus_wdata[29])));

    a_r4_w1c_pwron: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && bus_wdata[31]) |=> !status_q[31]);

    a_r8_first_load: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_event && cnt_q == '0) |=> status_q == 32'h8000_0000);

    a_r9_later_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_event && cnt_q != '0 && !btn_cold_evt && !status_q[27] && !status_q[28])
        |=> $stable(status_q));

    a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_event && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);

    a_r11_btn_set: assert property (@(posedge clk) disable iff (!rst_n)
        (btn_cold_evt && !(rst_event && cnt_q == '0)) |=> status_q[28]);
endmodule

bind rst_status_ctrl rst_status_ctrl_chk #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .CNT_W(CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .rst_event    (rst_event),
    .btn_cold_evt (btn_cold_evt),
    .reset_req    (reset_req),
    .status_q     (status_q),
    .cnt_q        (cnt_q)
);

// File: tb/tb_rst_status_ctrl.sv
// Bench: vector table of register writes, then directed reset-event cases.
module tb_rst_status_ctrl;
    localparam logic [15:0] ACT = 16'hF024;
    localparam int NV = 8;

    // Vector table: write address, write data, expected word, expected request.
    localparam logic [15:0] V_ADDR [NV] = '{16'hF024, 16'hF024, 16'hF024, 16'hF020,
                                           16'hF124, 16'hF024, 16'hF024, 16'hF027};
    localparam logic [31:0] V_DATA [NV] = '{32'h0000_0000, 32'h2000_0000, 32'h0000_0000,
                                           32'hFFFF_FFFF, 32'h6000_0000, 32'h8000_0000,
                                           32'h07FF_FFFF, 32'h2000_0000};
    localparam logic [31:0] V_EXP  [NV] = '{32'h8000_0000, 32'hA000_0000, 32'h8000_0000,
                                           32'h8000_0000, 32'h8000_0000, 32'h0000_0000,
                                           32'h0000_0000, 32'h2000_0000};
    localparam logic        V_REQ  [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
    // Requirement per vector: R4, R7, R5, R2, R2, R4, R3, R2 (low bits) and R7.
    localparam int          V_TAG  [NV] = '{4, 7, 5, 2, 2, 4, 3, 2};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = ACT;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_event = 1'b0;
    logic        btn_cold_evt = 1'b0;
    logic        btn_warm_evt = 1'b0;
    logic        reset_req;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rst_status_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_event(rst_event),
        .btn_cold_evt(btn_cold_evt), .btn_warm_evt(btn_warm_evt), .reset_req(reset_req)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // One clock of stimulus; afterwards the active word is addressed and sampled.
    task automatic step(input logic [15:0] a, input logic [31:0] d, input bit wr,
                        input bit evt, input bit bc, input bit bw);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = wr;
        rst_event = evt; btn_cold_evt = bc; btn_warm_evt = bw;
        @(negedge clk);
        bus_wr = 1'b0; rst_event = 1'b0; btn_cold_evt = 1'b0; btn_warm_evt = 1'b0;
        bus_addr = ACT; bus_wdata = '0;
        #1;
    endtask

    task automatic idle_req_low(input string tag);
        @(negedge clk); #1;
        check(reset_req == 1'b0, tag, {31'd0, reset_req}, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(bus_rdata == 32'd0, "R1 word in reset", bus_rdata, 32'd0);
        check(reset_req == 1'b0, "R1 req in reset", {31'd0, reset_req}, 32'd0);
        @(negedge clk); rst_n = 1'b1; #1;
        check(bus_rdata == 32'd0, "R1 word after reset", bus_rdata, 32'd0);

        // R8: first event after the counter is zero loads the power-on flag.
        step(ACT, 32'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        check(bus_rdata == 32'h8000_0000, "R8 first event", bus_rdata, 32'h8000_0000);

        for (int k = 0; k < NV; k++) begin
            step(V_ADDR[k], V_DATA[k], 1'b1, 1'b0, 1'b0, 1'b0);
            check(bus_rdata == V_EXP[k], $sformatf("R%0d vec %0d word", V_TAG[k], k),
                  bus_rdata, V_EXP[k]);
            check(reset_req == V_REQ[k], $sformatf("R%0d vec %0d req", V_TAG[k], k),
                  {31'd0, reset_req}, {31'd0, V_REQ[k]});
            idle_req_low($sformatf("R6 vec %0d pulse width", k));
        end

        // R9 / R7: counter nonzero and not cleared by the warm command.
        step(ACT, 32'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        check(bus_rdata == 32'h2000_0000, "R9 later event holds (R7 no clear)",
              bus_rdata, 32'h2000_0000);

        // R2: the inactive word reads zero while the word holds a value.
        @(negedge clk); bus_addr = 16'hF020; #1;
        check(bus_rdata == 32'd0, "R2 inactive word read", bus_rdata, 32'd0);
        bus_addr = ACT;

        // R6: cold command pulses once and re-arms the power-on flag.
        step(ACT, 32'h4000_0000, 1'b1, 1'b0, 1'b0, 1'b0);
        check(bus_rdata == 32'h4000_0000, "R5 cold bit written", bus_rdata, 32'h4000_0000);
        check(reset_req == 1'b1, "R6 request pulse", {31'd0, reset_req}, 32'd1);
        idle_req_low("R6 request single cycle");
        step(ACT, 32'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        check(bus_rdata == 32'h8000_0000, "R6 re-armed load", bus_rdata, 32'h8000_0000);

        // R11: buttons set their bits; set beats a same-cycle clear.
        step(ACT, 32'd0, 1'b0, 1'b0, 1'b1, 1'b0);
        check(bus_rdata == 32'h9000_0000, "R11 cold button", bus_rdata, 32'h9000_0000);
        step(ACT, 32'h0800_0000, 1'b1, 1'b0, 1'b0, 1'b1);
        check(bus_rdata == 32'h9800_0000, "R11 warm button beats clear",
              bus_rdata, 32'h9800_0000);
        step(ACT, 32'h1800_0000, 1'b1, 1'b0, 1'b0, 1'b0);
        check(bus_rdata == 32'h8000_0000, "R4 clear button bits", bus_rdata, 32'h8000_0000);

        // R12: a write during a reset event is dropped entirely.
        step(ACT, 32'hE000_0000, 1'b1, 1'b1, 1'b0, 1'b0);
        check(bus_rdata == 32'h8000_0000, "R12 write dropped", bus_rdata, 32'h8000_0000);
        check(reset_req == 1'b0, "R12 no request", {31'd0, reset_req}, 32'd0);
        step(ACT, 32'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        check(bus_rdata == 32'h8000_0000, "R12 counter not cleared", bus_rdata, 32'h8000_0000);

        // R10: many events never wrap the counter back to zero.
        step(ACT, 32'h8000_0000, 1'b1, 1'b0, 1'b0, 1'b0);
        check(bus_rdata == 32'd0, "R4 clear power-on flag", bus_rdata, 32'd0);
        for (int k = 0; k < 20; k++) begin
            step(ACT, 32'd0, 1'b0, 1'b1, 1'b0, 1'b0);
            check(bus_rdata == 32'd0, $sformatf("R10 event %0d no reload", k), bus_rdata, 32'd0);
        end
        step(ACT, 32'h4000_0000, 1'b1, 1'b0, 1'b0, 1'b0);
        step(ACT, 32'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        check(bus_rdata == 32'h8000_0000, "R10 clear from saturation (R6)",
              bus_rdata, 32'h8000_0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule